// File: doc/BRIEF.md
# Dual Timer Capture/Compare Channel

This block holds two timer channels that watch one external free-running counter. The counter itself is outside the block. The block receives the count value, a strobe that marks the cycle in which the count advances, a strobe that marks the advance that wraps the count back to zero, and a level that says the counter is stopped and held in reset.

Each channel takes a 4-bit configuration word. Bits [3:2] are the mode pair {mode-high, mode-low} and bits [1:0] are the edge/level pair. With this word a channel becomes one of the following:

- an input capture that latches the count on selected pin edges;
- an output compare or PWM generator;
- a disconnected channel that hands the pin back to the port logic and sets the pin's idle level.

Channel 0 can also run a buffered compare. It then takes its active threshold from whichever of the two channel registers was written last, and loads that threshold only at a wrap.

Software uses the channels through a register write port and a flag-clear strobe per channel. It reads the channel values on a read bus.

Top module: `tim_chpair`

## Requirements
- R1: After reset every configuration word is 0000, the channel values read 0, both flags and both error outputs are 0, `pin_oe` is 00 and `pin_out` is 11.
- R2: A channel whose edge/level pair is 00 drives `pin_oe` low. From the second clock edge after the configuration write, its `pin_out` equals the inverse of bit 2 (bit 2 = 1 gives low, 0 gives high).
- R3: Mode pair 00 with edge/level 01, 10 or 11 is an input capture on the rising edge, the falling edge, or either edge. The pin passes through SYNC_STAGES flops, and the capture happens on clock edge SYNC_STAGES+1 after the pin changes. A capture loads the count into the channel value, sets the channel flag, and keeps `pin_oe` low.
- R4: In compare mode, a match occurs only when `cnt_tick` is high and the count equals the active threshold. A match sets the flag and applies the action chosen by edge/level: 01 toggles, 10 drives low, 11 drives high. A compare channel drives `pin_oe` high.
- R5: In compare mode with action 10 or 11, a tick that also carries `cnt_ovf` drives the output to the level opposite the action. This takes priority over a match on the same tick. Action 01 ignores the wrap.
- R6: With a threshold of 0 (the value in force after the wrap), the wrap drives the output to the action level instead. Duty is then a flat 0% (action 10) or 100% (action 11) with no one-count pulse.
- R7: When channel 0 has bit 3 set and edge/level not 00, its active threshold is loaded at each wrap from the channel register written most recently. A write inside a period takes effect only from the next wrap. Channel 1's `pin_oe` is held low.
- R8: A `flag_clr` pulse clears the channel flag. A capture or match in the same cycle wins and leaves the flag set.
- R9: `mode_err` pulses high for one cycle after a configuration write that changes bits [3:2] while `cnt_halted` is low. Writes made while halted, or writes that keep bits [3:2], never raise it.
- R10: `cfg_err` is high exactly when channel 0's bits [3:2] are 01, channel 1's bit 2 is 1, and both edge/level pairs are non-zero.
- R11: `val_we` loads the channel value, which appears on `val_rdata` (channel i at bits [i*CNT_W +: CNT_W]). A capture in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current counter value |
| cnt_tick | input | 1 | Counter advances this cycle |
| cnt_ovf | input | 1 | This advance wraps the counter (valid with cnt_tick) |
| cnt_halted | input | 1 | Counter stopped and held in reset |
| cfg_we | input | 2 | Configuration write strobe per channel |
| cfg_wdata | input | 8 | Configuration words, channel i at [4i+3:4i] |
| val_we | input | 2 | Channel value write strobe |
| val_wdata | input | 2*CNT_W | Channel value write data |
| flag_clr | input | 2 | Flag clear strobe (software writes 0) |
| pin_in | input | 2 | Channel pins, inbound |
| val_rdata | output | 2*CNT_W | Channel value read data |
| flag | output | 2 | Channel event flags |
| pin_out | output | 2 | Channel pins, outbound level |
| pin_oe | output | 2 | Channel owns the pin |
| mode_err | output | 1 | Mode change while counter running (pulse) |
| cfg_err | output | 1 | Illegal dual unbuffered compare setting |

## Verification
The bench builds the block with a 4-bit counter and two synchronizer stages. The narrow counter makes a full period only 16 ticks long. That short period lets the bench walk every threshold from 0 to 15 under both drive-low and drive-high actions, and predict every pin level arithmetically. This covers the zero-threshold and wrap-coincident cases as well. With two stages, the capture latency is three edges, and the bench checks it exactly under each edge mode and each pin direction.

// File: rtl/tim_chpair_pkg.sv
package tim_chpair_pkg;

   typedef struct packed {
      logic mode_hi;
      logic mode_lo;
      logic lvl_hi;
      logic lvl_lo;
   } chcfg_t;

   typedef enum logic [1:0] {
      ACT_OFF    = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_LOW    = 2'b10,
      ACT_HIGH   = 2'b11
   } cmp_act_t;

   function automatic logic pin_linked(chcfg_t c);
      return c.lvl_hi | c.lvl_lo;
   endfunction

   function automatic logic is_capture(chcfg_t c);
      return !c.mode_hi && !c.mode_lo && pin_linked(c);
   endfunction

   function automatic logic is_compare(chcfg_t c);
      return (c.mode_hi | c.mode_lo) && pin_linked(c);
   endfunction

endpackage

// File: rtl/tim_chpair_sync.sv
module tim_chpair_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   logic [STAGES:0] shr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shr <= '0;
      else        shr <= {shr[STAGES-1:0], pin};
   end

   assign rise =  shr[STAGES-1] & ~shr[STAGES];
   assign fall = ~shr[STAGES-1] &  shr[STAGES];
endmodule

// File: rtl/tim_chpair_chan.sv
module tim_chpair_chan
   import tim_chpair_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  chcfg_t           cfg_wdata,
   input  logic             val_we,
   input  logic [CNT_W-1:0] val_wdata,
   input  logic             flag_clr,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_tick,
   input  logic             cnt_ovf,
   input  logic             rise,
   input  logic             fall,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [CNT_W-1:0] cmp_wrap,
   input  logic             yield_pin,
   output chcfg_t           cfg,
   output logic [CNT_W-1:0] val,
   output logic             flag,
   output logic             pin_out,
   output logic             pin_oe
);
   logic     cap_hit, cmp_on, match, wrap;
   cmp_act_t act;

   assign act     = cmp_act_t'({cfg.lvl_hi, cfg.lvl_lo});
   assign cmp_on  = is_compare(cfg);
   assign cap_hit = is_capture(cfg) && ((cfg.lvl_lo && rise) || (cfg.lvl_hi && fall));
   assign match   = cmp_on && cnt_tick && (cnt_val == cmp_val);
   assign wrap    = cmp_on && cnt_tick && cnt_ovf && (act != ACT_TOGGLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg  <= '0;
         val  <= '0;
         flag <= 1'b0;
      end else begin
         if (cfg_we) cfg <= cfg_wdata;
         if (cap_hit)     val <= cnt_val;
         else if (val_we) val <= val_wdata;
         if (cap_hit || match) flag <= 1'b1;
         else if (flag_clr)    flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_out <= 1'b1;
      end else if (!pin_linked(cfg)) begin
         pin_out <= ~cfg.mode_lo;
      end else if (wrap) begin
         if (cmp_wrap == '0) pin_out <= (act == ACT_HIGH);
         else                pin_out <= (act == ACT_LOW);
      end else if (match) begin
         case (act)
            ACT_TOGGLE: pin_out <= ~pin_out;
            ACT_LOW:    pin_out <= 1'b0;
            ACT_HIGH:   pin_out <= 1'b1;
            default:    pin_out <= pin_out;
         endcase
      end
   end

   assign pin_oe = cmp_on && !yield_pin;
endmodule

// File: rtl/tim_chpair.sv
module tim_chpair
   import tim_chpair_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   cnt_val,
   input  logic               cnt_tick,
   input  logic               cnt_ovf,
   input  logic               cnt_halted,
   input  logic [1:0]         cfg_we,
   input  logic [7:0]         cfg_wdata,
   input  logic [1:0]         val_we,
   input  logic [2*CNT_W-1:0] val_wdata,
   input  logic [1:0]         flag_clr,
   input  logic [1:0]         pin_in,
   output logic [2*CNT_W-1:0] val_rdata,
   output logic [1:0]         flag,
   output logic [1:0]         pin_out,
   output logic [1:0]         pin_oe,
   output logic               mode_err,
   output logic               cfg_err
);
   localparam int NCH = 2;
   localparam int CFG_W = $bits(chcfg_t);

   if (CNT_W < 2) begin : g_bad_width
      $error("tim_chpair: CNT_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tim_chpair: SYNC_STAGES must be at least 2");
   end

   chcfg_t           cfg_q   [NCH];
   logic [CNT_W-1:0] val_q   [NCH];
   logic [CNT_W-1:0] cmp_sel [NCH];
   logic [CNT_W-1:0] cmp_nxt [NCH];
   logic [NCH-1:0]   rise, fall, yield, ms_chg;

   logic             buf_on, last_wr1;
   logic [CNT_W-1:0] buf_act, buf_next;

   assign buf_on   = cfg_q[0].mode_hi && pin_linked(cfg_q[0]);
   assign buf_next = last_wr1 ? val_q[1] : val_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_wr1 <= 1'b0;
         buf_act  <= '0;
      end else begin
         if (val_we[1])      last_wr1 <= 1'b1;
         else if (val_we[0]) last_wr1 <= 1'b0;
         if (buf_on && cnt_tick && cnt_ovf) buf_act <= buf_next;
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      if (i == 0) begin : g_bufsrc
         assign cmp_sel[i] = buf_on ? buf_act  : val_q[i];
         assign cmp_nxt[i] = buf_on ? buf_next : val_q[i];
         assign yield[i]   = 1'b0;
      end else begin : g_plain
         assign cmp_sel[i] = val_q[i];
         assign cmp_nxt[i] = val_q[i];
         assign yield[i]   = buf_on;
      end

      assign ms_chg[i] = cfg_we[i] && !cnt_halted &&
                         (cfg_wdata[CFG_W*i+2 +: 2] != {cfg_q[i].mode_hi, cfg_q[i].mode_lo});

      tim_chpair_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .pin  (pin_in[i]),
         .rise (rise[i]),
         .fall (fall[i])
      );

      tim_chpair_chan #(.CNT_W(CNT_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (cfg_we[i]),
         .cfg_wdata(chcfg_t'(cfg_wdata[CFG_W*i +: CFG_W])),
         .val_we   (val_we[i]),
         .val_wdata(val_wdata[CNT_W*i +: CNT_W]),
         .flag_clr (flag_clr[i]),
         .cnt_val  (cnt_val),
         .cnt_tick (cnt_tick),
         .cnt_ovf  (cnt_ovf),
         .rise     (rise[i]),
         .fall     (fall[i]),
         .cmp_val  (cmp_sel[i]),
         .cmp_wrap (cmp_nxt[i]),
         .yield_pin(yield[i]),
         .cfg      (cfg_q[i]),
         .val      (val_q[i]),
         .flag     (flag[i]),
         .pin_out  (pin_out[i]),
         .pin_oe   (pin_oe[i])
      );

      assign val_rdata[CNT_W*i +: CNT_W] = val_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_err <= 1'b0;
      else        mode_err <= |ms_chg;
   end

   assign cfg_err = !cfg_q[0].mode_hi && cfg_q[0].mode_lo && cfg_q[1].mode_lo &&
                    pin_linked(cfg_q[0]) && pin_linked(cfg_q[1]);
endmodule

// File: rtl/tim_chpair_chk.sv
module tim_chpair_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cnt_tick,
   input logic       cnt_halted,
   input logic [1:0] cfg_we,
   input logic [3:0] cfg0,
   input logic [3:0] cfg1,
   input logic [1:0] pin_out,
   input logic [1:0] pin_oe,
   input logic       mode_err,
   input logic       cfg_err
);
   AST_IDLE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg0[1:0] == 2'b00) |-> !pin_oe[0]); // R2

   AST_CAPTURE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg1[3:2] == 2'b00) |-> !pin_oe[1]); // R3

   AST_BUF_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg0[3] && cfg0[1:0] != 2'b00) |-> !pin_oe[1]); // R7

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe[0] && !cnt_tick && !cfg_we[0]) |=> $stable(pin_out[0])); // R4

   AST_MODE_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_err) |-> ($past(!cnt_halted) && $past(|cfg_we))); // R9

   AST_CFG_ERR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (cfg0[3:2] == 2'b01 && cfg1[2] && cfg1[1:0] != 2'b00)); // R10
endmodule

bind tim_chpair tim_chpair_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_tick  (cnt_tick),
   .cnt_halted(cnt_halted),
   .cfg_we    (cfg_we),
   .cfg0      (cfg_q[0]),
   .cfg1      (cfg_q[1]),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .mode_err  (mode_err),
   .cfg_err   (cfg_err)
);

// File: tb/tim_chpair_tb.sv
module tim_chpair_tb;
   localparam int W   = 4;
   localparam int MAX = (1 << W) - 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [W-1:0]   cnt_val = '0;
   logic           cnt_tick = 1'b0, cnt_ovf = 1'b0, cnt_halted = 1'b1;
   logic [1:0]     cfg_we = '0, val_we = '0, flag_clr = '0, pin_in = '0;
   logic [7:0]     cfg_wdata = '0;
   logic [2*W-1:0] val_wdata = '0;
   logic [2*W-1:0] val_rdata;
   logic [1:0]     flag, pin_out, pin_oe;
   logic           mode_err, cfg_err;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tim_chpair #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
      .cnt_ovf(cnt_ovf), .cnt_halted(cnt_halted), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .val_we(val_we), .val_wdata(val_wdata),
      .flag_clr(flag_clr), .pin_in(pin_in), .val_rdata(val_rdata),
      .flag(flag), .pin_out(pin_out), .pin_oe(pin_oe),
      .mode_err(mode_err), .cfg_err(cfg_err)
   );

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr_cfg(int ch, logic [3:0] d);
      cfg_we[ch] = 1'b1;
      cfg_wdata[4*ch +: 4] = d;
      @(negedge clk);
      cfg_we = '0;
   endtask

   task automatic wr_val(int ch, int v);
      val_we[ch] = 1'b1;
      val_wdata[W*ch +: W] = W'(v);
      @(negedge clk);
      val_we = '0;
   endtask

   task automatic clr_flags();
      flag_clr = 2'b11;
      @(negedge clk);
      flag_clr = '0;
   endtask

   // one tick at count c; writes value wv to channel wch when wch >= 0
   task automatic tick(int c, int wch, int wv);
      cnt_val  = W'(c);
      cnt_tick = 1'b1;
      cnt_ovf  = (c == MAX);
      if (wch >= 0) begin
         val_we[wch] = 1'b1;
         val_wdata[W*wch +: W] = W'(wv);
      end
      @(negedge clk);
      cnt_tick = 1'b0;
      cnt_ovf  = 1'b0;
      val_we   = '0;
   endtask

   function automatic int pwm_exp(int cmp, int c, bit high_act);
      int lvl;
      if (cmp == 0) lvl = 0;
      else          lvl = (c < cmp || c == MAX) ? 1 : 0;
      return high_act ? 1 - lvl : lvl;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int exp_val;
      int lvl;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1", "pin_oe", pin_oe, 0);
      check("R1", "pin_out", pin_out, 3);
      check("R1", "flag", flag, 0);
      check("R1", "mode_err", mode_err, 0);
      check("R1", "cfg_err", cfg_err, 0);
      check("R1", "val_rdata", val_rdata, 0);

      // R2 disconnected preset levels
      for (int m = 0; m < 4; m++) begin
         wr_cfg(0, {m[1:0], 2'b00});
         @(negedge clk);
         check("R2", "preset oe", pin_oe[0], 0);
         check("R2", "preset level", pin_out[0], m[0] ? 0 : 1);
      end

      // R11 value write and readback
      wr_val(1, 10);
      check("R11", "val1 readback", val_rdata[W +: W], 10);
      wr_val(0, 3);
      check("R11", "val0 readback", val_rdata[0 +: W], 3);
      exp_val = 3;

      // R3 capture, each edge mode, each pin direction
      for (int e = 1; e < 4; e++) begin
         wr_cfg(0, {2'b00, e[1:0]});
         clr_flags();
         for (int d = 0; d < 2; d++) begin
            bit hit;
            cnt_val = W'(4 * e + d + 1);
            pin_in[0] = ~pin_in[0];
            hit = pin_in[0] ? e[0] : e[1];
            @(negedge clk);
            @(negedge clk);
            check("R3", "flag before latency", flag[0], 0);
            @(negedge clk);
            check("R3", "capture flag", flag[0], hit);
            if (hit) exp_val = 4 * e + d + 1;
            check("R3", "captured value", val_rdata[0 +: W], exp_val);
            check("R3", "capture oe", pin_oe[0], 0);
            clr_flags();
         end
      end
      pin_in[0] = 1'b0;
      repeat (3) @(negedge clk);

      // R5 / R6 PWM sweep, drive-low and drive-high actions
      for (int a = 0; a < 2; a++) begin
         wr_cfg(0, a ? 4'b0111 : 4'b0110);
         for (int cmp = 0; cmp <= MAX; cmp++) begin
            wr_val(0, cmp);
            for (int p = 0; p < 2; p++)
               for (int c = 0; c <= MAX; c++) begin
                  tick(c, -1, 0);
                  if (p == 1)
                     check(cmp == 0 ? "R6" : "R5", "pwm level", pin_out[0],
                           pwm_exp(cmp, c, a[0]));
               end
         end
         check("R4", "compare oe", pin_oe[0], 1);
      end

      // R4 toggle, and no match without tick
      wr_cfg(0, 4'b0101);
      wr_val(0, 6);
      clr_flags();
      lvl = pin_out[0];
      for (int c = 0; c <= MAX; c++) begin
         tick(c, -1, 0);
         if (c == 6) lvl = 1 - lvl;
         check("R4", "toggle level", pin_out[0], lvl);
      end
      check("R4", "match flag", flag[0], 1);
      // R8 clear
      clr_flags();
      check("R8", "flag cleared", flag[0], 0);
      cnt_val = 6;
      @(negedge clk);
      check("R4", "no match without tick", pin_out[0], lvl);
      check("R4", "no flag without tick", flag[0], 0);
      // R8 set wins over clear
      flag_clr = 2'b01;
      tick(6, -1, 0);
      flag_clr = '0;
      check("R8", "set beats clear", flag[0], 1);
      clr_flags();

      // R7 buffered compare
      wr_cfg(0, 4'b1010);
      wr_cfg(1, 4'b0111);
      wr_val(0, 5);
      for (int c = 0; c <= MAX; c++) tick(c, -1, 0);
      check("R7", "channel 1 yields pin", pin_oe[1], 0);
      check("R7", "channel 0 owns pin", pin_oe[0], 1);
      for (int c = 0; c <= MAX; c++) begin
         tick(c, c == 2 ? 1 : -1, 9);
         check("R7", "period cmp5", pin_out[0], pwm_exp(5, c, 1'b0));
      end
      for (int c = 0; c <= MAX; c++) begin
         tick(c, c == 2 ? 0 : -1, 3);
         check("R7", "period cmp9", pin_out[0], pwm_exp(9, c, 1'b0));
      end
      for (int c = 0; c <= MAX; c++) begin
         tick(c, -1, 0);
         check("R7", "period cmp3", pin_out[0], pwm_exp(3, c, 1'b0));
      end

      // R9 mode change while running
      cnt_halted = 1'b0;
      wr_cfg(0, 4'b0110);
      check("R9", "mode_err pulse", mode_err, 1);
      @(negedge clk);
      check("R9", "mode_err one cycle", mode_err, 0);
      wr_cfg(0, 4'b0111);
      check("R9", "same mode no error", mode_err, 0);
      cnt_halted = 1'b1;
      wr_cfg(0, 4'b1010);
      check("R9", "halted no error", mode_err, 0);

      // R10 illegal dual compare
      wr_cfg(0, 4'b0101);
      wr_cfg(1, 4'b0101);
      check("R10", "dual unbuffered", cfg_err, 1);
      wr_cfg(1, 4'b0100);
      check("R10", "ch1 disconnected", cfg_err, 0);
      wr_cfg(1, 4'b1101);
      check("R10", "ch1 mode_lo set", cfg_err, 1);
      wr_cfg(0, 4'b1101);
      check("R10", "ch0 buffered", cfg_err, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule